// File: doc/BRIEF.md
# One-Address Accumulator Core

This block is a compact processor whose only working register is a 32-bit accumulator. It runs from address zero after reset and fetches a program from a single byte-wide memory port. Every instruction except the stop code is three bytes: an opcode, then the low and the high byte of a memory address. A load puts the word at that address into the accumulator. A store writes the accumulator out and leaves it as it was. Add and subtract combine the accumulator, always as the left operand, with the word at that address, and the result replaces the accumulator.

Each memory access moves one byte per cycle. A 32-bit operand is therefore four accesses at consecutive addresses, starting with the least significant byte at the lowest address. Two counters record how many instruction bytes were fetched and how many data bytes were read or written. These let an environment measure the memory traffic of a program. The stop code ends execution. An opcode the core does not recognise also ends execution and raises an error flag.

Top module: `acc_core`

## Requirements
- R1: While reset is held, the program counter, the accumulator and both byte counters read zero, and the halted and error flags are low.
- R2: Opcode 0x01 (load) sets the accumulator to the 32-bit word at the operand address. The word is assembled little-endian: the byte at the address is bits 7:0 and the byte at address+3 is bits 31:24.
- R3: Opcode 0x02 (store) writes the accumulator to the operand address as four bytes, bits 7:0 at the address and bits 31:24 at address+3. The accumulator keeps its value.
- R4: Opcode 0x10 (add) sets the accumulator to the accumulator plus the memory word, wrapping modulo 2^32.
- R5: Opcode 0x11 (subtract) sets the accumulator to the accumulator minus the memory word, wrapping modulo 2^32. The accumulator is the minuend.
- R6: A memory instruction is three bytes: the opcode, the address bits 7:0, then the address bits 15:8. The program counter advances by exactly 3 per memory instruction.
- R7: Opcode 0xFF (stop) is one byte. After it, the halted flag is high and the program counter points just past the stop byte. The core then makes no further memory access and its program counter does not change.
- R8: Any other opcode sets both the halted flag and the error flag after that single byte is fetched. No address byte is fetched for it.
- R9: The instruction-byte counter adds one for every opcode or address byte fetched. The data-byte counter adds one for every operand byte read or written. Exactly one of the two counters moves on each cycle with an active memory access, and neither moves otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_en | output | 1 | A memory byte access happens this cycle |
| mem_we | output | 1 | The access is a write |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as the address |
| acc_o | output | 32 | Accumulator value |
| pc_o | output | 16 | Program counter |
| halted | output | 1 | Execution has stopped |
| error | output | 1 | Stopped on an unknown opcode |
| ibytes | output | 32 | Instruction bytes fetched |
| dbytes | output | 32 | Data bytes transferred |

## Verification
On the last operand cycle of an arithmetic instruction, two things happen in the same clock. The fourth byte arrives from memory, and the accumulator is rewritten with the ALU result, which is built from that very byte together with the three bytes already buffered. The bench provokes this by storing a freshly computed sum and then reusing it as an operand in the next few instructions. It also runs the classic sequence A=B+C, B=A+C, D=A-B. Each stored result is judged byte by byte in memory against values worked out from the requirements, with a wrap-around case included, and the two traffic counters are compared with the byte counts the program implies.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam logic [7:0] OPC_LOAD  = 8'h01;
    localparam logic [7:0] OPC_STORE = 8'h02;
    localparam logic [7:0] OPC_ADD   = 8'h10;
    localparam logic [7:0] OPC_SUB   = 8'h11;
    localparam logic [7:0] OPC_STOP  = 8'hFF;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ALO,
        ST_AHI,
        ST_XFER,
        ST_STOP
    } state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end
endmodule

// File: rtl/acc_byte_pick.sv
module acc_byte_pick #(
    parameter int W  = 32,
    parameter int IW = 2
) (
    input  logic [W-1:0]  word,
    input  logic [IW-1:0] sel,
    output logic [7:0]    byte_o
);
    localparam int NB = W / 8;

    logic [7:0] lane [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane[g] = word[8*g +: 8];
    end

    assign byte_o = lane[sel];
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [DATA_W-1:0] acc_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              halted,
    output logic              error,
    output logic [CNT_W-1:0]  ibytes,
    output logic [CNT_W-1:0]  dbytes
);
    localparam int NBYTES = DATA_W / 8;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

    typedef struct packed {
        state_e              st;
        logic [ADDR_W-1:0]   pc;
        logic [7:0]          opc;
        logic [ADDR_W-1:0]   ea;
        logic [IDX_W-1:0]    idx;
        logic [DATA_W-1:0]   sh;
        logic [DATA_W-1:0]   acc;
        logic                stop;
        logic                err;
        logic [CNT_W-1:0]    icnt;
        logic [CNT_W-1:0]    dcnt;
    } core_t;

    core_t q, d;

    logic [DATA_W-1:0] word_in;
    logic [DATA_W-1:0] alu_y;
    logic [7:0]        st_byte;

    // Each new byte enters at the top; after the last one the word is in order.
    assign word_in = {mem_rdata, q.sh[DATA_W-1:8]};

    acc_alu #(.W(DATA_W)) u_alu (
        .a   (q.acc),
        .b   (word_in),
        .sub (q.opc == OPC_SUB),
        .y   (alu_y)
    );

    acc_byte_pick #(.W(DATA_W), .IW(IDX_W)) u_pick (
        .word   (q.acc),
        .sel    (q.idx),
        .byte_o (st_byte)
    );

    always_comb begin
        d         = q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.pc;
        mem_wdata = 8'h00;
        unique case (q.st)
            ST_OPC: begin
                mem_en = 1'b1;
                d.opc  = mem_rdata;
                d.pc   = q.pc + ADDR_W'(1);
                d.icnt = q.icnt + CNT_W'(1);
                unique case (mem_rdata)
                    OPC_LOAD, OPC_STORE, OPC_ADD, OPC_SUB: d.st = ST_ALO;
                    OPC_STOP: begin
                        d.st   = ST_STOP;
                        d.stop = 1'b1;
                    end
                    default: begin
                        d.st   = ST_STOP;
                        d.stop = 1'b1;
                        d.err  = 1'b1;
                    end
                endcase
            end
            ST_ALO: begin
                mem_en = 1'b1;
                d.ea   = ADDR_W'(mem_rdata);
                d.pc   = q.pc + ADDR_W'(1);
                d.icnt = q.icnt + CNT_W'(1);
                d.st   = ST_AHI;
            end
            ST_AHI: begin
                mem_en = 1'b1;
                d.ea   = q.ea | (ADDR_W'(mem_rdata) << 8);
                d.pc   = q.pc + ADDR_W'(1);
                d.icnt = q.icnt + CNT_W'(1);
                d.idx  = '0;
                d.st   = ST_XFER;
            end
            ST_XFER: begin
                mem_en    = 1'b1;
                mem_we    = (q.opc == OPC_STORE);
                mem_addr  = q.ea + ADDR_W'(q.idx);
                mem_wdata = st_byte;
                d.dcnt    = q.dcnt + CNT_W'(1);
                d.sh      = word_in;
                if (q.idx == IDX_LAST) begin
                    d.st = ST_OPC;
                    if (q.opc == OPC_LOAD)
                        d.acc = word_in;
                    else if (q.opc != OPC_STORE)
                        d.acc = alu_y;
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                end
            end
            default: begin
                d.st = ST_STOP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_OPC, default: '0};
        end else begin
            q <= d;
        end
    end

    assign acc_o  = q.acc;
    assign pc_o   = q.pc;
    assign halted = q.stop;
    assign error  = q.err;
    assign ibytes = q.icnt;
    assign dbytes = q.dcnt;
endmodule

// File: rtl/acc_core_sva.sv
module acc_core_sva #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_en,
    input logic              mem_we,
    input logic [DATA_W-1:0] acc_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic              halted,
    input logic              error,
    input logic [CNT_W-1:0]  ibytes,
    input logic [CNT_W-1:0]  dbytes
);
    // R3: a store byte never disturbs the accumulator
    a_r3_store_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(acc_o));

    // R3: writes only happen as part of an access
    a_r3_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R6: the program counter holds during operand transfers
    a_r6_pc_hold_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(pc_o));

    // R7: once stopped, stay stopped and silent
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_o) && !mem_en));

    // R8: an error always comes with a halt
    a_r8_error_halts: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> halted);

    // R9: each access bumps the combined traffic count by one
    a_r9_one_byte_per_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> ((ibytes + dbytes) == ($past(ibytes) + $past(dbytes) + CNT_W'(1))));

    // R9: no access means no counting
    a_r9_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |=> ($stable(ibytes) && $stable(dbytes)));
endmodule

bind acc_core acc_core_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_en (mem_en),
    .mem_we (mem_we),
    .acc_o  (acc_o),
    .pc_o   (pc_o),
    .halted (halted),
    .error  (error),
    .ibytes (ibytes),
    .dbytes (dbytes)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [31:0] acc_o;
    logic [15:0] pc_o;
    logic        halted, error;
    logic [31:0] ibytes, dbytes;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem [1024];

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end

    acc_core u_acc_core (
        .clk(clk), .rst_n(rst_n),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_o(acc_o), .pc_o(pc_o), .halted(halted), .error(error),
        .ibytes(ibytes), .dbytes(dbytes)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    endtask

    task automatic put_ins(input int at, input logic [7:0] opc, input logic [15:0] a);
        mem[at]   = opc;
        mem[at+1] = a[7:0];
        mem[at+2] = a[15:8];
    endtask

    task automatic put_word(input int at, input logic [31:0] w);
        for (int i = 0; i < 4; i++) mem[at+i] = w[8*i +: 8];
    endtask

    function automatic logic [31:0] get_word(input int at);
        return {mem[at+3], mem[at+2], mem[at+1], mem[at]};
    endfunction

    task automatic start_and_wait();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
    endtask

    task automatic t_reset();
        clear_mem();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pc", {16'h0, pc_o}, 32'h0);
        check("R1 acc", acc_o, 32'h0);
        check("R1 ibytes", ibytes, 32'h0);
        check("R1 dbytes", dbytes, 32'h0);
        check("R1 flags", {30'h0, halted, error}, 32'h0);
    endtask

    task automatic t_load();
        clear_mem();
        put_ins(0, 8'h01, 16'h0123);
        mem[3] = 8'hFF;
        put_word(16'h0123, 32'h348fd6a0);
        start_and_wait();
        check("R2 load value", acc_o, 32'h348fd6a0);
        check("R6 R7 pc after load and stop", {16'h0, pc_o}, 32'd4);
        check("R9 ibytes load", ibytes, 32'd4);
        check("R9 dbytes load", dbytes, 32'd4);
        check("R7 halted no error", {30'h0, halted, error}, 32'h2);
    endtask

    task automatic t_arith_wrap();
        clear_mem();
        put_ins(0,  8'h01, 16'h0200);
        put_ins(3,  8'h10, 16'h0204);
        put_ins(6,  8'h02, 16'h0210);
        put_ins(9,  8'h11, 16'h0208);
        put_ins(12, 8'h02, 16'h0214);
        mem[15] = 8'hFF;
        put_word(16'h0200, 32'hFFFFFFF0);
        put_word(16'h0204, 32'h00000020);
        put_word(16'h0208, 32'h00000030);
        start_and_wait();
        check("R4 add wraps", get_word(16'h0210), 32'h00000010);
        check("R5 sub wraps, acc minuend", get_word(16'h0214), 32'hFFFFFFE0);
        check("R3 store byte0 is lsb", {24'h0, mem[16'h0214]}, 32'hE0);
        check("R3 store byte3 is msb", {24'h0, mem[16'h0217]}, 32'hFF);
        check("R3 acc kept after store", acc_o, 32'hFFFFFFE0);
        check("R6 pc after five instr", {16'h0, pc_o}, 32'd16);
        check("R9 ibytes arith", ibytes, 32'd16);
        check("R9 dbytes arith", dbytes, 32'd20);
    endtask

    task automatic t_sequence();
        // A=0x300 B=0x304 C=0x308 D=0x30C ; A=B+C; B=A+C; D=A-B
        clear_mem();
        put_ins(0,  8'h01, 16'h0304);
        put_ins(3,  8'h10, 16'h0308);
        put_ins(6,  8'h02, 16'h0300);
        put_ins(9,  8'h10, 16'h0308);
        put_ins(12, 8'h02, 16'h0304);
        put_ins(15, 8'h01, 16'h0300);
        put_ins(18, 8'h11, 16'h0304);
        put_ins(21, 8'h02, 16'h030C);
        mem[24] = 8'hFF;
        put_word(16'h0304, 32'd5);
        put_word(16'h0308, 32'd7);
        start_and_wait();
        check("R4 A=B+C", get_word(16'h0300), 32'd12);
        check("R4 B=A+C", get_word(16'h0304), 32'd19);
        check("R5 D=A-B", get_word(16'h030C), 32'hFFFFFFF9);
        check("R3 C untouched", get_word(16'h0308), 32'd7);
        check("R9 ibytes sequence", ibytes, 32'd25);
        check("R9 dbytes sequence", dbytes, 32'd32);
    endtask

    task automatic t_bad_opcode();
        clear_mem();
        put_ins(0, 8'h42, 16'h0100);
        start_and_wait();
        check("R8 halted and error", {30'h0, halted, error}, 32'h3);
        check("R8 pc one byte", {16'h0, pc_o}, 32'd1);
        check("R8 ibytes one", ibytes, 32'd1);
        check("R8 dbytes zero", dbytes, 32'd0);
    endtask

    task automatic t_stop_silent();
        int seen;
        logic [15:0] pc0;
        clear_mem();
        put_ins(0, 8'h10, 16'h0100);
        mem[3] = 8'hFF;
        put_ins(4, 8'h02, 16'h0100);
        put_word(16'h0100, 32'h11223344);
        start_and_wait();
        pc0  = pc_o;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_en) seen++;
        end
        check("R7 no access after stop", seen, 0);
        check("R7 pc frozen", {16'h0, pc_o}, {16'h0, pc0});
        check("R7 pc past stop", {16'h0, pc0}, 32'd4);
        check("R7 later store not run", get_word(16'h0100), 32'h11223344);
        check("R4 add from zero acc", acc_o, 32'h11223344);
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_arith_wrap();
        t_sequence();
        t_bad_opcode();
        t_stop_silent();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule